// File: doc/BRIEF.md
# Byte-Lane Static RAM Behavioural Model

This block is a clock-sampled behavioural model of a 16-bit asynchronous static RAM. It has an active-low chip select, write strobe, read strobe and one active-low byte strobe per 8-bit lane. On every rising clock edge the model samples these pins. Chip-level simulations use it wherever the real memory would sit on a board-level bus. Its tri-state bus is split into a data-out vector and one drive flag per lane, so a testbench can resolve the bus itself and detect contention.

The pins are decoded every cycle into one of four modes: `M_STANDBY`, `M_OUTDIS`, `M_READ` and `M_WRITE`. A small write controller has two states. `WS_IDLE` moves to `WS_OPEN` on any sample whose mode is `M_WRITE`, which means chip select low, write strobe low and at least one byte strobe low. `WS_OPEN` stays in `WS_OPEN` while that overlap persists, and each such sample captures the address, data and lane mask again. `WS_OPEN` returns to `WS_IDLE` on the first sample outside the overlap, and on that edge the captured lanes are committed to the array. Reset forces `WS_IDLE` and drops any captured write. Storage depth is set by `ADDR_W`, and the upper address bits are ignored.

Top module: `byte_sram_model`

## Requirements
- R1: While `cs_n` is 1, both bits of `lane_drv` are 0 and `dq_out` is 0, whatever the other pins are.
- R2: With `cs_n`=0, `we_n`=1 and `oe_n`=1, both lanes are undriven (`lane_drv`=0, `dq_out`=0).
- R3: With `cs_n`=0 and `bs_n`=2'b11, both lanes are undriven and no write is captured, even if `we_n`=0.
- R4: With `cs_n`=0, `we_n`=1 and `oe_n`=0, `lane_drv[0]` is 1 exactly when `bs_n[0]`=0 and then `dq_out[7:0]` shows the stored low byte. `lane_drv[1]` is 1 exactly when `bs_n[1]`=0 and then `dq_out[15:8]` shows the stored high byte. An undriven lane reads as 0.
- R5: With `cs_n`=0 and `we_n`=0, no lane is driven, whatever `oe_n` is.
- R6: A write updates only the lanes whose `bs_n` bit was 0 in the last overlapping sample. The other lane of that word keeps its earlier value.
- R7: A write takes effect on the first sampled edge where the overlap has ended, and a read is visible after that edge. It uses the address and data of the last sample inside the overlap, so values held earlier in a long overlap are lost.
- R8: Only `addr[ADDR_W-1:0]` selects the word. Addresses that differ only above that field reach the same word.
- R9: If `rst_n` is asserted while a write overlap is open, the pending write is discarded and never reaches the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset of the write controller |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read output enable, active low |
| bs_n | input | DATA_W/LANE_W | Byte strobes, bit 0 for bits 7:0 and bit 1 for bits 15:8, active low |
| addr | input | ADDR_FULL | Word address; only the low ADDR_W bits are used |
| dq_in | input | DATA_W | Bus value sampled for writes |
| dq_out | output | DATA_W | Read data; zero on any undriven lane |
| lane_drv | output | DATA_W/LANE_W | Per-lane drive flag (1 = lane drives the bus) |

## Verification
The bench builds the model with `ADDR_W`=4 and the full 18-bit address port. This keeps the array at 16 words, so every word can be initialised at the start, and random 18-bit addresses alias heavily and exercise the wrap rule. A behavioural model in the bench, built from an associative array and a pending-write record, predicts the drive flags and data on every cycle. Directed sequences cover a long overlap with changing data, overlaps ended by each enable in turn, single-lane writes and a reset inside an open overlap. A random phase then mixes all pin combinations.

// File: rtl/sram_pkg.sv
package sram_pkg;
    typedef enum logic [1:0] {
        M_STANDBY = 2'd0,
        M_OUTDIS  = 2'd1,
        M_READ    = 2'd2,
        M_WRITE   = 2'd3
    } sram_mode_e;

    typedef enum logic {
        WS_IDLE = 1'b0,
        WS_OPEN = 1'b1
    } wr_state_e;
endpackage

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
    import sram_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             cs_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [LANES-1:0] bs_n,
    output sram_mode_e       mode,
    output logic [LANES-1:0] lane_sel
);
    always_comb begin
        lane_sel = ~bs_n;
        if (cs_n) begin
            mode = M_STANDBY;
        end else if (lane_sel == '0) begin
            mode = M_OUTDIS;
        end else if (!we_n) begin
            mode = M_WRITE;
        end else if (oe_n) begin
            mode = M_OUTDIS;
        end else begin
            mode = M_READ;
        end
    end
endmodule

// File: rtl/sram_write_ctrl.sv
module sram_write_ctrl
    import sram_pkg::*;
#(
    parameter int IDX_W  = 10,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sram_mode_e        mode,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] data,
    input  logic [LANES-1:0]  lane_sel,
    output logic              commit,
    output logic [IDX_W-1:0]  commit_idx,
    output logic [DATA_W-1:0] commit_data,
    output logic [LANES-1:0]  commit_mask
);
    wr_state_e         state, state_nx;
    logic [IDX_W-1:0]  pend_idx;
    logic [DATA_W-1:0] pend_data;
    logic [LANES-1:0]  pend_mask;

    always_comb begin
        unique case (state)
            WS_IDLE: state_nx = (mode == M_WRITE) ? WS_OPEN : WS_IDLE;
            WS_OPEN: state_nx = (mode == M_WRITE) ? WS_OPEN : WS_IDLE;
            default: state_nx = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= WS_IDLE;
            pend_idx  <= '0;
            pend_data <= '0;
            pend_mask <= '0;
        end else begin
            state <= state_nx;
            if (mode == M_WRITE) begin
                pend_idx  <= idx;
                pend_data <= data;
                pend_mask <= lane_sel;
            end
        end
    end

    always_comb begin
        commit      = (state == WS_OPEN) && (mode != M_WRITE);
        commit_idx  = pend_idx;
        commit_data = pend_data;
        commit_mask = pend_mask;
    end

    p_no_commit_in_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_WRITE) |-> !commit);
    p_single_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);
    p_commit_after_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(mode) == M_WRITE);
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
    parameter int IDX_W  = 10,
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [LANES-1:0]        wr_mask,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [LANES*LANE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[g]) begin
                mem[wr_idx] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = mem[rd_idx];
    end

    p_commit_has_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_mask != '0);
endmodule

// File: rtl/byte_sram_model.sv
module byte_sram_model
    import sram_pkg::*;
#(
    parameter int ADDR_FULL = 18,
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 16,
    parameter int LANE_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n,
    input  logic                       we_n,
    input  logic                       oe_n,
    input  logic [DATA_W/LANE_W-1:0]   bs_n,
    input  logic [ADDR_FULL-1:0]       addr,
    input  logic [DATA_W-1:0]          dq_in,
    output logic [DATA_W-1:0]          dq_out,
    output logic [DATA_W/LANE_W-1:0]   lane_drv
);
    localparam int LANES = DATA_W / LANE_W;

    sram_mode_e        mode;
    logic [LANES-1:0]  lane_sel;
    logic [ADDR_W-1:0] idx;
    logic              commit;
    logic [ADDR_W-1:0] commit_idx;
    logic [DATA_W-1:0] commit_data;
    logic [LANES-1:0]  commit_mask;
    logic [DATA_W-1:0] rd_data;

    assign idx = addr[ADDR_W-1:0];

    sram_mode_decode #(.LANES(LANES)) u_decode (
        .cs_n     (cs_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .bs_n     (bs_n),
        .mode     (mode),
        .lane_sel (lane_sel)
    );

    sram_write_ctrl #(.IDX_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_wctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .idx         (idx),
        .data        (dq_in),
        .lane_sel    (lane_sel),
        .commit      (commit),
        .commit_idx  (commit_idx),
        .commit_data (commit_data),
        .commit_mask (commit_mask)
    );

    sram_lane_array #(.IDX_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit),
        .wr_idx  (commit_idx),
        .wr_data (commit_data),
        .wr_mask (commit_mask),
        .rd_idx  (idx),
        .rd_data (rd_data)
    );

    always_comb begin
        lane_drv = (mode == M_READ) ? lane_sel : '0;
        for (int i = 0; i < LANES; i++) begin
            dq_out[i*LANE_W +: LANE_W] = lane_drv[i] ? rd_data[i*LANE_W +: LANE_W] : '0;
        end
    end

    p_standby_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (lane_drv == '0 && dq_out == '0));
    p_oe_high_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && we_n && oe_n) |-> lane_drv == '0);
    p_lane_needs_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_drv & bs_n) == '0);
    p_write_no_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !we_n) |-> lane_drv == '0);
endmodule

// File: tb/byte_sram_model_test.sv
module byte_sram_model_test;
    localparam int AW    = 4;
    localparam int AF    = 18;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [1:0]    bs_n = 2'b11;
    logic [AF-1:0] addr = '0;
    logic [15:0]   dq_in = '0;
    logic [15:0]   dq_out;
    logic [1:0]    lane_drv;

    int checks = 0;
    int fails  = 0;

    logic [15:0] ref_mem [int];
    bit          pend = 0;
    int          p_idx;
    logic [15:0] p_data;
    logic [1:0]  p_mask;

    always #5 clk = ~clk;

    byte_sram_model #(.ADDR_FULL(AF), .ADDR_W(AW), .DATA_W(16), .LANE_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .bs_n(bs_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .lane_drv(lane_drv)
    );

    task automatic model_edge();
        bit ovl;
        if (!rst_n) begin
            pend = 0;
        end else begin
            ovl = !cs_n && !we_n && (bs_n != 2'b11);
            if (pend && !ovl) begin
                if (p_mask[0]) ref_mem[p_idx][7:0]  = p_data[7:0];
                if (p_mask[1]) ref_mem[p_idx][15:8] = p_data[15:8];
            end
            pend = ovl;
            if (ovl) begin
                p_idx  = int'(addr) % DEPTH;
                p_data = dq_in;
                p_mask = ~bs_n;
            end
        end
    endtask

    function automatic string pin_tag();
        if (cs_n) return "R1";
        if (bs_n == 2'b11) return "R3";
        if (!we_n) return "R5";
        if (oe_n) return "R2";
        return "R4";
    endfunction

    task automatic check(input string tag);
        logic [1:0]  exp_drv;
        logic [15:0] exp_dq, word;
        exp_drv = (!cs_n && we_n && !oe_n) ? ~bs_n : 2'b00;
        word = ref_mem.exists(int'(addr) % DEPTH) ? ref_mem[int'(addr) % DEPTH] : 16'h0;
        exp_dq = {exp_drv[1] ? word[15:8] : 8'h00, exp_drv[0] ? word[7:0] : 8'h00};
        checks++;
        if (lane_drv !== exp_drv) begin
            fails++;
            $display("FAIL %s lane_drv actual %b expected %b", pin_tag(), lane_drv, exp_drv);
        end
        checks++;
        if (dq_out !== exp_dq) begin
            fails++;
            $display("FAIL %s dq_out actual %h expected %h", tag, dq_out, exp_dq);
        end
    endtask

    task automatic cyc(input logic c, input logic w, input logic o, input logic [1:0] b,
                       input logic [AF-1:0] a, input logic [15:0] d, input string tag);
        cs_n = c; we_n = w; oe_n = o; bs_n = b; addr = a; dq_in = d;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(10 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        // Reset state, standby (R1)
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 2'b00, 18'h5, 16'hFFFF, "R1");
        rst_n = 1'b1;
        // Initialise every word
        for (int i = 0; i < DEPTH; i++) begin
            cyc(0, 0, 1, 2'b00, AF'(i), 16'hA5C3 ^ (16'h1111 * i[15:0]), "R6");
            cyc(1, 1, 1, 2'b11, AF'(i), 16'h0, "R7");
        end
        // Reads with each strobe pattern (R4)
        for (int i = 0; i < DEPTH; i++) begin
            cyc(0, 1, 0, 2'b00, AF'(i), 16'h0, "R4");
            cyc(0, 1, 0, 2'b10, AF'(i), 16'h0, "R4");
            cyc(0, 1, 0, 2'b01, AF'(i), 16'h0, "R4");
        end
        // Output disabled (R2) and no strobes with write low (R3)
        cyc(0, 1, 1, 2'b00, 18'h3, 16'h0, "R2");
        cyc(0, 0, 0, 2'b11, 18'h3, 16'hDEAD, "R3");
        cyc(0, 1, 0, 2'b00, 18'h3, 16'h0, "R3");
        // Low-lane write with oe low (R5, R6)
        cyc(0, 0, 0, 2'b10, 18'h7, 16'h1234, "R5");
        cyc(0, 1, 0, 2'b00, 18'h7, 16'h0, "R6");
        // High-lane write ended by strobe release (R6)
        cyc(0, 0, 1, 2'b01, 18'h8, 16'hBEEF, "R6");
        cyc(0, 0, 1, 2'b11, 18'h8, 16'h0, "R6");
        cyc(0, 1, 0, 2'b00, 18'h8, 16'h0, "R6");
        // Long overlap, data and address change, last sample wins (R7)
        cyc(0, 0, 0, 2'b00, 18'h9, 16'h1111, "R7");
        cyc(0, 0, 0, 2'b00, 18'h9, 16'h2222, "R7");
        cyc(0, 0, 0, 2'b01, 18'hA, 16'h3333, "R7");
        cyc(0, 1, 0, 2'b00, 18'hA, 16'h0, "R7");
        cyc(0, 1, 0, 2'b00, 18'h9, 16'h0, "R7");
        // Overlap ended by chip select
        cyc(0, 0, 1, 2'b00, 18'hB, 16'h7777, "R7");
        cyc(1, 0, 1, 2'b00, 18'hB, 16'h0, "R7");
        cyc(0, 1, 0, 2'b00, 18'hB, 16'h0, "R7");
        // Address wrap (R8)
        cyc(0, 0, 1, 2'b00, 18'h3_FFF5, 16'hC0DE, "R8");
        cyc(1, 1, 1, 2'b11, 18'h0, 16'h0, "R8");
        cyc(0, 1, 0, 2'b00, 18'h0_0005, 16'h0, "R8");
        cyc(0, 1, 0, 2'b00, 18'h2_0015, 16'h0, "R8");
        // Reset inside an open overlap discards the write (R9)
        cyc(0, 0, 1, 2'b00, 18'hC, 16'h9999, "R9");
        rst_n = 1'b0;
        cyc(1, 1, 1, 2'b11, 18'hC, 16'h0, "R9");
        rst_n = 1'b1;
        cyc(0, 1, 0, 2'b00, 18'hC, 16'h0, "R9");
        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic [3:0] r;
            r = 4'($urandom);
            cyc(r[0] & r[1], r[2], r[3], 2'($urandom), AF'($urandom), 16'($urandom), "R6");
        end
        summary();
        $finish;
    end
endmodule